// File: doc/BRIEF.md
# SIMD Variable Blend Unit

This execution unit merges two packed vectors of 32-bit lanes under a per-lane select vector. Each lane of the result comes from the second source when its select bit is set and from the first source when it is clear. The unit supports two operand forms. The legacy form always blends four lanes, and the destination doubles as the first source, so the bits above those lanes are carried over from the first source. The extended form blends four or eight lanes, depending on a length input, and zeroes every bit above the last active lane. The move is pure bit copying, so lanes holding integers, NaNs or denormals pass through unchanged, and no floating-point exception is ever produced.

The unit also reports which architectural register supplies the select vector. In the extended form the index comes from the upper nibble of the 8-bit immediate, and its top bit is forced to zero in 32-bit mode. In the legacy form the index is always register 0. An extended-form request with W=1 raises the undefined-opcode fault. The write enable is then withheld and the result register keeps its old contents. Results appear one clock after the request.

The output side is a three-state machine.
- **ST_IDLE**: no valid output.
- **ST_WRITE**: a valid result to be written.
- **ST_FAULT**: a valid request that faulted.

From any state, a cycle without `in_valid` goes to ST_IDLE. A valid request with no fault goes to ST_WRITE, and a valid faulting request goes to ST_FAULT. Reset forces ST_IDLE.

Top module: `vblend_unit`

## Requirements
- R1: Lane n occupies bits [32n+31:32n]. Select bit n is `mask_vec[n]`. An active lane takes `src_b` when that bit is 1 and `src_a` when it is 0.
- R2: Legacy form (`form_vext`=0): only lanes 0..3 are blended. Result bits 255:128 equal `src_a[255:128]`, and `out_mask_idx` is 0.
- R3: Extended form with `len256`=0: lanes 0..3 are blended and result bits 255:128 are zero.
- R4: Extended form with `len256`=1: all eight lanes are blended.
- R5: Extended form in 64-bit mode (`mode64`=1): `out_mask_idx` equals `imm[7:4]`.
- R6: Extended form in 32-bit mode: `out_mask_idx` equals `{1'b0, imm[6:4]}`.
- R7: Extended form with `w_bit`=1 asserts `out_fault` and leaves `out_result` unchanged. `w_bit` has no effect in the legacy form.
- R8: `imm[3:0]` has no effect on any output.
- R9: Lane contents are copied bit-exact, including NaN, infinity and denormal encodings.
- R10: `out_valid` is `in_valid` delayed by one clock. A cycle without `in_valid` leaves `out_result` and `out_mask_idx` unchanged.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_wr_en`, `out_fault`, `out_mask_idx` and `out_result`.
- R12: `out_wr_en` is high exactly when `out_valid` is high and `out_fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| form_vext | input | 1 | 0 = legacy form, 1 = extended form |
| len256 | input | 1 | Extended form length: 0 = 128 bits, 1 = 256 bits |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| w_bit | input | 1 | Extension W bit (must be 0) |
| imm | input | 8 | Immediate; bits 7:4 give the select register index |
| src_a | input | 256 | First source (also the destination in the legacy form) |
| src_b | input | 256 | Second source |
| mask_vec | input | 256 | Select vector; bit n governs lane n |
| out_valid | output | 1 | Result cycle valid |
| out_wr_en | output | 1 | Destination write enable |
| out_fault | output | 1 | Undefined-opcode fault |
| out_mask_idx | output | 4 | Index of the register that holds the select vector |
| out_result | output | 256 | Blended result |

## Verification
The hardest case to reach is a fault that holds the result. It is only visible when a faulting request follows a request whose result differed, so a stale or clobbered register shows up. The sweep crosses all sixteen combinations of form, length, mode and W bit with every immediate upper nibble and all 256 select patterns. It issues them back to back, so faulting and writing requests alternate with varied predecessors. Idle cycles with scrambled inputs are placed between groups to show that the held values survive.

// File: rtl/vblend_pkg.sv
package vblend_pkg;
    parameter int unsigned LANE_W       = 32;
    parameter int unsigned MAX_LANES    = 8;
    parameter int unsigned LEGACY_LANES = 4;
    parameter int unsigned IDX_W        = 4;
    parameter int unsigned IMM_W        = 8;
    localparam int unsigned VEC_W       = LANE_W * MAX_LANES;

    typedef enum logic {
        FORM_LEGACY = 1'b0,
        FORM_VEXT   = 1'b1
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAULT = 2'd2
    } out_state_e;
endpackage

// File: rtl/vblend_decode.sv
module vblend_decode
    import vblend_pkg::*;
#(
    parameter int unsigned LANES  = MAX_LANES,
    parameter int unsigned LEGACY = LEGACY_LANES,
    parameter int unsigned IW     = IDX_W
) (
    input  form_e             form,
    input  logic              len256,
    input  logic              mode64,
    input  logic              w_bit,
    input  logic [IW-1:0]     imm_hi,
    output logic [LANES-1:0]  lane_on,
    output logic              keep_upper,
    output logic              fault,
    output logic [IW-1:0]     mask_idx
);
    localparam int unsigned HALF = LANES / 2;

    int unsigned active_cnt;

    always_comb begin
        if (form == FORM_LEGACY) begin
            active_cnt = LEGACY;
        end else if (len256) begin
            active_cnt = LANES;
        end else begin
            active_cnt = HALF;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane_on
        assign lane_on[i] = (i < active_cnt);
    end

    assign keep_upper = (form == FORM_LEGACY);
    assign fault      = (form == FORM_VEXT) && w_bit;

    always_comb begin
        if (form == FORM_LEGACY) begin
            mask_idx = '0;
        end else begin
            mask_idx = imm_hi;
            if (!mode64) begin
                mask_idx[IW-1] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vblend_lanes.sv
module vblend_lanes
    import vblend_pkg::*;
#(
    parameter int unsigned LW    = LANE_W,
    parameter int unsigned LANES = MAX_LANES
) (
    input  logic [LW*LANES-1:0] vec_a,
    input  logic [LW*LANES-1:0] vec_b,
    input  logic [LANES-1:0]    sel,
    input  logic [LANES-1:0]    lane_on,
    input  logic                keep_upper,
    output logic [LW*LANES-1:0] vec_y
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        logic [LW-1:0] a_l, b_l;
        assign a_l = vec_a[n*LW +: LW];
        assign b_l = vec_b[n*LW +: LW];
        always_comb begin
            if (lane_on[n]) begin
                vec_y[n*LW +: LW] = sel[n] ? b_l : a_l;
            end else if (keep_upper) begin
                vec_y[n*LW +: LW] = a_l;
            end else begin
                vec_y[n*LW +: LW] = '0;
            end
        end
    end
endmodule

// File: rtl/vblend_unit.sv
module vblend_unit
    import vblend_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             form_vext,
    input  logic             len256,
    input  logic             mode64,
    input  logic             w_bit,
    input  logic [IMM_W-1:0] imm,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] mask_vec,
    output logic             out_valid,
    output logic             out_wr_en,
    output logic             out_fault,
    output logic [IDX_W-1:0] out_mask_idx,
    output logic [VEC_W-1:0] out_result
);
    localparam int unsigned HALF_W = VEC_W / 2;

    form_e                form;
    logic [MAX_LANES-1:0] lane_on;
    logic                 keep_upper;
    logic                 dec_fault;
    logic [IDX_W-1:0]     dec_idx;
    logic [VEC_W-1:0]     blended;
    out_state_e           state, state_nx;

    wire unused_inputs = &{1'b0, imm[IMM_W-IDX_W-1:0], mask_vec[VEC_W-1:MAX_LANES]};

    assign form = form_e'(form_vext);

    vblend_decode u_decode (
        .form       (form),
        .len256     (len256),
        .mode64     (mode64),
        .w_bit      (w_bit),
        .imm_hi     (imm[IMM_W-1 -: IDX_W]),
        .lane_on    (lane_on),
        .keep_upper (keep_upper),
        .fault      (dec_fault),
        .mask_idx   (dec_idx)
    );

    vblend_lanes u_lanes (
        .vec_a      (src_a),
        .vec_b      (src_b),
        .sel        (mask_vec[MAX_LANES-1:0]),
        .lane_on    (lane_on),
        .keep_upper (keep_upper),
        .vec_y      (blended)
    );

    // Next-state: every state reacts to the arriving request the same way
    always_comb begin
        unique case (state)
            ST_IDLE, ST_WRITE, ST_FAULT: begin
                if (!in_valid)      state_nx = ST_IDLE;
                else if (dec_fault) state_nx = ST_FAULT;
                else                state_nx = ST_WRITE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        out_valid = 1'b0;
        out_wr_en = 1'b0;
        out_fault = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WRITE: begin
                out_valid = 1'b1;
                out_wr_en = 1'b1;
            end
            ST_FAULT: begin
                out_valid = 1'b1;
                out_fault = 1'b1;
            end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_result   <= '0;
            out_mask_idx <= '0;
        end else if (in_valid) begin
            out_mask_idx <= dec_idx;
            if (!dec_fault) out_result <= blended;
        end
    end

    a_r7_fault_holds: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> $stable(out_result));
    a_r12_fault_blocks_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_wr_en, out_fault}));
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));
    a_r6_idx_limited: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode64) |=> !out_mask_idx[IDX_W-1]);
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_vext && !len256 && !w_bit) |=> (out_result[VEC_W-1:HALF_W] == '0));
    a_r2_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !form_vext) |=> (out_result[VEC_W-1:HALF_W] == $past(src_a[VEC_W-1:HALF_W])));
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && out_mask_idx == '0));
endmodule

// File: tb/tb_vblend_unit.sv
`timescale 1ns/1ps
module tb_vblend_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         form_vext = 1'b0, len256 = 1'b0, mode64 = 1'b0, w_bit = 1'b0;
    logic [7:0]   imm = '0;
    logic [255:0] src_a = '0, src_b = '0, mask_vec = '0;
    logic         out_valid, out_wr_en, out_fault;
    logic [3:0]   out_mask_idx;
    logic [255:0] out_result;

    int n_tests = 0;
    int n_fail  = 0;
    logic [255:0] last_res = '0;
    logic [3:0]   last_idx = '0;

    always #2 clk = ~clk;

    vblend_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .form_vext(form_vext),
        .len256(len256), .mode64(mode64), .w_bit(w_bit), .imm(imm),
        .src_a(src_a), .src_b(src_b), .mask_vec(mask_vec),
        .out_valid(out_valid), .out_wr_en(out_wr_en), .out_fault(out_fault),
        .out_mask_idx(out_mask_idx), .out_result(out_result)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] pat(input int seed);
        logic [255:0] v;
        for (int n = 0; n < 8; n++) v[n*32 +: 32] = 32'h9E3779B9 * (seed * 8 + n + 1) ^ 32'h5A5A0F0F;
        return v;
    endfunction

    function automatic logic [255:0] ref_blend(input logic fv, input logic l256,
            input logic [255:0] a, input logic [255:0] b, input logic [7:0] m);
        logic [255:0] y;
        int cnt;
        cnt = !fv ? 4 : (l256 ? 8 : 4);
        for (int n = 0; n < 8; n++) begin
            if (n < cnt)  y[n*32 +: 32] = m[n] ? b[n*32 +: 32] : a[n*32 +: 32];
            else if (!fv) y[n*32 +: 32] = a[n*32 +: 32];
            else          y[n*32 +: 32] = '0;
        end
        return y;
    endfunction

    // Drive at a falling edge, check at the next falling edge (one register stage)
    task automatic issue(input logic fv, input logic l256, input logic m64, input logic w,
            input logic [7:0] im, input logic [255:0] a, input logic [255:0] b, input logic [7:0] m);
        logic flt;
        logic [3:0] eidx;
        string rt, it;
        in_valid = 1'b1; form_vext = fv; len256 = l256; mode64 = m64; w_bit = w;
        imm = im; src_a = a; src_b = b; mask_vec = {pat(im)} & ~256'hFF | {248'h0, m};
        flt  = fv & w;
        eidx = !fv ? 4'd0 : (m64 ? im[7:4] : {1'b0, im[6:4]});
        if (!flt) last_res = ref_blend(fv, l256, a, b, m);
        last_idx = eidx;
        rt = flt ? "R7 fault hold" : (!fv ? "R2 legacy" : (l256 ? "R4 ext256" : "R3 ext128"));
        it = !fv ? "R2 legacy idx" : (m64 ? "R5 idx" : "R6 idx32");
        @(negedge clk);
        chk(rt, out_result, last_res);
        chk(it, {252'h0, out_mask_idx}, {252'h0, eidx});
        chk("R10 valid", {255'h0, out_valid}, 256'h1);
        chk("R7 fault flag", {255'h0, out_fault}, {255'h0, flt});
        chk("R12 wr_en", {255'h0, out_wr_en}, {255'h0, !flt});
    endtask

    task automatic idle_cycle(input int seed);
        in_valid = 1'b0; src_a = pat(seed); src_b = ~pat(seed); mask_vec = pat(seed + 7);
        imm = imm ^ 8'hFF; w_bit = ~w_bit;
        @(negedge clk);
        chk("R10 idle valid", {255'h0, out_valid}, 256'h0);
        chk("R10 idle wr_en", {254'h0, out_wr_en, out_fault}, 256'h0);
        chk("R10 idle result held", out_result, last_res);
        chk("R10 idle idx held", {252'h0, out_mask_idx}, {252'h0, last_idx});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [255:0] r_first;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset valid", {253'h0, out_valid, out_wr_en, out_fault}, 256'h0);
        chk("R11 reset result", out_result, 256'h0);
        chk("R11 reset idx", {252'h0, out_mask_idx}, 256'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 idle after reset", {255'h0, out_valid}, 256'h0);

        // R9: special encodings copied bit-exact
        issue(1'b1, 1'b1, 1'b1, 1'b0, 8'h30,
              {32'h7F800001, 32'hFF800000, 32'h00000001, 32'h80000000,
               32'h7FC00000, 32'hFFFFFFFF, 32'h007FFFFF, 32'h12345678},
              {32'h00000000, 32'h7F800000, 32'h80000001, 32'hFFC00001,
               32'h7FBFFFFF, 32'h00800000, 32'hDEADBEEF, 32'h3F800000}, 8'hA5);
        chk("R9 bit exact", out_result,
            {32'h00000000, 32'hFF800000, 32'h80000001, 32'h80000000,
             32'h7FC00000, 32'h00800000, 32'h007FFFFF, 32'h3F800000});

        // R1: single-lane selection walk on the full width
        for (int k = 0; k < 8; k++) begin
            issue(1'b1, 1'b1, 1'b1, 1'b0, 8'h10, '0, '1, 8'(1 << k));
            chk("R1 lane walk", out_result, 256'({32'hFFFFFFFF} << (32 * k)));
        end

        // R8: low immediate nibble has no effect
        issue(1'b1, 1'b1, 1'b1, 1'b0, 8'hB0, pat(11), pat(12), 8'h3C);
        r_first = out_result;
        issue(1'b1, 1'b1, 1'b1, 1'b0, 8'hBF, pat(11), pat(12), 8'h3C);
        chk("R8 imm low ignored result", out_result, r_first);
        chk("R8 imm low ignored idx", {252'h0, out_mask_idx}, 256'hB);

        // Near-exhaustive sweep: all configurations, index nibbles, select patterns
        for (int c = 0; c < 16; c++) begin
            for (int h = 0; h < 16; h++) begin
                for (int m = 0; m < 256; m++) begin
                    issue(c[0], c[1], c[2], c[3], {h[3:0], m[3:0] ^ h[3:0]},
                          pat(c * 4096 + h * 256 + m), ~pat(m + h), m[7:0]);
                end
                idle_cycle(c + h);
            end
        end

        // R11: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        chk("R11 reset again", {250'h0, out_mask_idx, out_valid, out_fault}, 256'h0);
        chk("R11 reset result again", out_result, 256'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule